// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block carries out the architectural state change a three-level privileged processor core makes when it accepts an exception or an interrupt. The core presents a one-cycle trap request together with a cause code, an interrupt flag, the address of the trapping instruction and a trap value. The block looks up two delegation masks to decide which privilege level will service the trap. It saves the context into that level's own bank of trap registers and stacks the interrupt-enable and previous-privilege bits of a shared status word. It then switches the current privilege and redirects the program counter to that level's trap vector.

Return-from-trap instructions, interrupt arbitration and the general register decoder sit outside the block. A small register write port loads the trap vectors, delegation masks, status word and current privilege during setup. A combinational read port exposes the same state so that the block can be observed.

Privilege encoding used everywhere: user = 2'b00, supervisor = 2'b01, machine = 2'b11.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the current privilege is machine, next_pc equals RESET_PC, trap_taken is low, and the status word, both delegation masks and every bank register read as zero.
- R2: The handler level is machine by default. It is supervisor when the current level is not machine and bit trap_code of the machine delegation mask is set. A trap taken in machine mode is always handled in machine mode.
- R3: The handler level is user whenever the current level is user and bit trap_code of the supervisor delegation mask is set, whatever the machine mask holds. A trap from supervisor or machine never reaches user.
- R4: Entering a user handler copies user-IE (status bit 0) into user-PIE (bit 4) and clears user-IE. All other status bits are unchanged.
- R5: Entering a supervisor handler copies supervisor-IE (bit 1) into supervisor-PIE (bit 5), clears supervisor-IE, and writes bit 0 of the interrupted privilege into the supervisor previous-privilege bit (bit 8). Other status bits are unchanged.
- R6: Entering a machine handler copies machine-IE (bit 3) into machine-PIE (bit 7), clears machine-IE, and writes the interrupted privilege into the machine previous-privilege field (bits 12:11). Other status bits are unchanged.
- R7: The handler bank's cause register receives trap_code in its low CODE_W bits and the interrupt flag in bit XLEN-1. All other bits are zero.
- R8: The handler bank's epc register receives trap_pc and its tval register receives trap_val. The current privilege becomes the handler level. The registers of the other two banks and every trap vector are left unchanged.
- R9: In the cycle after a request, trap_taken is high for exactly one cycle and next_pc equals the handler's trap vector with its low two bits cleared. next_pc does not change without a trap or a reset.
- R10: Write/read map on the 4-bit address. Address 0 is status: only bits 0,1,3,4,5,7,8,11,12 are stored, and the other bits read 0. Address 1 is the machine delegation mask and address 2 is the supervisor delegation mask. Address 3 is the current privilege, where a written value of 2'b10 is stored as machine. Addresses 4-7, 8-11 and 12-15 are the user, supervisor and machine banks, each laid out as vector, epc, cause, tval. A write in the same cycle as a trap request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request, one cycle per trap |
| trap_is_irq | input | 1 | High for an interrupt, low for a synchronous exception |
| trap_code | input | CODE_W | Cause code; also indexes the delegation masks |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_val | input | XLEN | Trap value to record |
| csr_we | input | 1 | Setup write enable |
| csr_addr | input | 4 | Setup write address |
| csr_wdata | input | XLEN | Setup write data |
| csr_raddr | input | 4 | Read address |
| csr_rdata | output | XLEN | Read data, combinational |
| cur_priv | output | 2 | Current privilege level |
| next_pc | output | XLEN | Redirect target after a trap, reset vector after reset |
| trap_taken | output | 1 | High for one cycle after a trap is accepted |

## Verification
The properties assume that trap_req, trap_code and trap_is_irq carry known values in every cycle after reset. They also assume that a request lasts exactly one cycle per trap and is never issued while reset is active. The bench drives every input to a defined value before reset is released and raises trap_req only for single cycles, each time at a falling edge. Setup writes are also issued only at falling edges, and only one of them coincides with a trap request, on purpose, to exercise the write-drop rule.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRV_U = 2'b00;
    localparam logic [1:0] PRV_S = 2'b01;
    localparam logic [1:0] PRV_M = 2'b11;

    localparam int STAT_W = 13;

    typedef struct packed {
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       upie;
        logic       mie;
        logic       sie;
        logic       uie;
    } stat_t;

    function automatic logic [STAT_W-1:0] stat_to_word(input stat_t s);
        logic [STAT_W-1:0] w;
        w        = '0;
        w[0]     = s.uie;
        w[1]     = s.sie;
        w[3]     = s.mie;
        w[4]     = s.upie;
        w[5]     = s.spie;
        w[7]     = s.mpie;
        w[8]     = s.spp;
        w[12:11] = s.mpp;
        return w;
    endfunction

    function automatic stat_t word_to_stat(input logic [STAT_W-1:0] w);
        stat_t s;
        s.uie  = w[0];
        s.sie  = w[1];
        s.mie  = w[3];
        s.upie = w[4];
        s.spie = w[5];
        s.mpie = w[7];
        s.spp  = w[8];
        s.mpp  = w[12:11];
        return s;
    endfunction

    function automatic logic [1:0] priv_to_bank(input logic [1:0] p);
        case (p)
            PRV_U:   return 2'd0;
            PRV_S:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/trap_mode_sel.sv
module trap_mode_sel
    import trap_pkg::*;
#(
    parameter int CODE_W  = 5,
    localparam int DELEG_W = 1 << CODE_W
) (
    input  logic [1:0]         cur_priv,
    input  logic [CODE_W-1:0]  code,
    input  logic [DELEG_W-1:0] m_deleg,
    input  logic [DELEG_W-1:0] s_deleg,
    output logic [1:0]         handler
);
    always_comb begin
        handler = PRV_M;
        if (cur_priv != PRV_M && m_deleg[code]) begin
            handler = PRV_S;
        end
        if (cur_priv == PRV_U && s_deleg[code]) begin
            handler = PRV_U;
        end
    end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
    import trap_pkg::*;
(
    input  stat_t      stat_old,
    input  logic [1:0] cur_priv,
    input  logic [1:0] handler,
    output stat_t      stat_new
);
    always_comb begin
        stat_new = stat_old;
        case (handler)
            PRV_U: begin
                stat_new.upie = stat_old.uie;
                stat_new.uie  = 1'b0;
            end
            PRV_S: begin
                stat_new.spp  = cur_priv[0];
                stat_new.spie = stat_old.sie;
                stat_new.sie  = 1'b0;
            end
            default: begin
                stat_new.mpp  = cur_priv;
                stat_new.mpie = stat_old.mie;
                stat_new.mie  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_trap,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   tvec_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   tval_q
);
    typedef struct packed {
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } bank_t;

    bank_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sel_trap) begin
            regs_d.cause              = '0;
            regs_d.cause[CODE_W-1:0]  = trap_code;
            regs_d.cause[XLEN-1]      = trap_is_irq;
            regs_d.epc                = trap_pc;
            regs_d.tval               = trap_val;
        end else if (wr_en) begin
            case (wr_field)
                2'd0:    regs_d.tvec  = wr_data;
                2'd1:    regs_d.epc   = wr_data;
                2'd2:    regs_d.cause = wr_data;
                default: regs_d.tval  = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tvec_q  = regs_q.tvec;
    assign epc_q   = regs_q.epc;
    assign cause_q = regs_q.cause;
    assign tval_q  = regs_q.tval;

    // R8: an idle bank keeps its contents
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_trap && !wr_en) |=> $stable(regs_q));

    // R8: a trap never alters the vector
    p_tvec_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_trap |=> $stable(regs_q.tvec));

    // R7: cause carries code and interrupt flag
    p_cause_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_trap |=> (regs_q.cause[XLEN-1] == $past(trap_is_irq)) &&
                     (regs_q.cause[CODE_W-1:0] == $past(trap_code)));

    // R8: epc and tval capture the request
    p_ctx_saved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_trap |=> (regs_q.epc == $past(trap_pc)) && (regs_q.tval == $past(trap_val)));
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 5,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic              csr_we,
    input  logic [3:0]        csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [3:0]        csr_raddr,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [1:0]        cur_priv,
    output logic [XLEN-1:0]   next_pc,
    output logic              trap_taken
);
    localparam int DELEG_W = 1 << CODE_W;
    localparam int NBANK   = 3;

    typedef struct packed {
        logic [1:0]         priv;
        stat_t              stat;
        logic [DELEG_W-1:0] m_deleg;
        logic [DELEG_W-1:0] s_deleg;
        logic [XLEN-1:0]    pc;
        logic               taken;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]      handler;
    logic [1:0]      hidx;
    stat_t           stat_stacked;
    logic [XLEN-1:0] bank_tvec  [NBANK];
    logic [XLEN-1:0] bank_epc   [NBANK];
    logic [XLEN-1:0] bank_cause [NBANK];
    logic [XLEN-1:0] bank_tval  [NBANK];
    logic [XLEN-1:0] sel_tvec;

    trap_mode_sel #(.CODE_W(CODE_W)) u_mode_sel (
        .cur_priv (ctl_q.priv),
        .code     (trap_code),
        .m_deleg  (ctl_q.m_deleg),
        .s_deleg  (ctl_q.s_deleg),
        .handler  (handler)
    );

    trap_status_stack u_stack (
        .stat_old (ctl_q.stat),
        .cur_priv (ctl_q.priv),
        .handler  (handler),
        .stat_new (stat_stacked)
    );

    assign hidx = priv_to_bank(handler);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel_this;
        logic wr_this;
        assign sel_this = trap_req && (hidx == 2'(g));
        assign wr_this  = csr_we && !trap_req && (csr_addr[3:2] == 2'(g + 1));
        trap_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_trap    (sel_this),
            .trap_is_irq (trap_is_irq),
            .trap_code   (trap_code),
            .trap_pc     (trap_pc),
            .trap_val    (trap_val),
            .wr_en       (wr_this),
            .wr_field    (csr_addr[1:0]),
            .wr_data     (csr_wdata),
            .tvec_q      (bank_tvec[g]),
            .epc_q       (bank_epc[g]),
            .cause_q     (bank_cause[g]),
            .tval_q      (bank_tval[g])
        );
    end

    assign sel_tvec = bank_tvec[hidx];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.taken = trap_req;
        if (trap_req) begin
            ctl_d.priv = handler;
            ctl_d.stat = stat_stacked;
            ctl_d.pc   = {sel_tvec[XLEN-1:2], 2'b00};
        end else if (csr_we && csr_addr[3:2] == 2'd0) begin
            case (csr_addr[1:0])
                2'd0:    ctl_d.stat    = word_to_stat(csr_wdata[STAT_W-1:0]);
                2'd1:    ctl_d.m_deleg = csr_wdata[DELEG_W-1:0];
                2'd2:    ctl_d.s_deleg = csr_wdata[DELEG_W-1:0];
                default: ctl_d.priv    = (csr_wdata[1:0] == 2'b10) ? PRV_M : csr_wdata[1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.priv    <= PRV_M;
            ctl_q.stat    <= '0;
            ctl_q.m_deleg <= '0;
            ctl_q.s_deleg <= '0;
            ctl_q.pc      <= RESET_PC;
            ctl_q.taken   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_raddr[3:2])
            2'd0: begin
                case (csr_raddr[1:0])
                    2'd0:    csr_rdata = XLEN'(stat_to_word(ctl_q.stat));
                    2'd1:    csr_rdata = XLEN'(ctl_q.m_deleg);
                    2'd2:    csr_rdata = XLEN'(ctl_q.s_deleg);
                    default: csr_rdata = XLEN'(ctl_q.priv);
                endcase
            end
            default: begin
                case (csr_raddr[1:0])
                    2'd0:    csr_rdata = bank_tvec[csr_raddr[3:2] - 2'd1];
                    2'd1:    csr_rdata = bank_epc[csr_raddr[3:2] - 2'd1];
                    2'd2:    csr_rdata = bank_cause[csr_raddr[3:2] - 2'd1];
                    default: csr_rdata = bank_tval[csr_raddr[3:2] - 2'd1];
                endcase
            end
        endcase
    end

    assign cur_priv   = ctl_q.priv;
    assign next_pc    = ctl_q.pc;
    assign trap_taken = ctl_q.taken;

    p_taken_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> trap_taken);

    p_no_spurious_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !trap_taken);

    p_pc_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (next_pc[1:0] == 2'b00));

    p_pc_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> $stable(next_pc));

    p_machine_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == PRV_M) |=> (cur_priv == PRV_M));

    p_no_user_climb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv != PRV_U) |=> (cur_priv != PRV_U));

    p_mie_stacked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == PRV_M) |=>
            (!ctl_q.stat.mie && ctl_q.stat.mpp == PRV_M && ctl_q.stat.mpie == $past(ctl_q.stat.mie)));

    p_user_stacked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && handler == PRV_U) |=>
            (!ctl_q.stat.uie && ctl_q.stat.upie == $past(ctl_q.stat.uie) && $stable(ctl_q.stat.mie)));

    p_write_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && csr_we && csr_addr[3:2] == 2'd0 && csr_addr[1] != csr_addr[0])
            |=> ($stable(ctl_q.m_deleg) && $stable(ctl_q.s_deleg)));
endmodule

// File: tb/trap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module trap_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam int CODE_W = 5;
    localparam logic [31:0] RST_VEC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0;
    logic trap_is_irq = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0] trap_pc = '0;
    logic [XLEN-1:0] trap_val = '0;
    logic csr_we = 1'b0;
    logic [3:0] csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [3:0] csr_raddr = '0;
    logic [XLEN-1:0] csr_rdata;
    logic [1:0] cur_priv;
    logic [XLEN-1:0] next_pc;
    logic trap_taken;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RST_VEC)) u_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_val(trap_val),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_raddr(csr_raddr), .csr_rdata(csr_rdata), .cur_priv(cur_priv),
        .next_pc(next_pc), .trap_taken(trap_taken)
    );

    // vector: {start_priv[1:0], mdeleg_bit, sdeleg_bit, irq, code[4:0], expected_handler[1:0]}
    localparam logic [11:0] VEC [8] = '{
        {2'b11, 1'b1, 1'b1, 1'b0, 5'd0,  2'b11},
        {2'b01, 1'b0, 1'b1, 1'b1, 5'd2,  2'b11},
        {2'b01, 1'b1, 1'b0, 1'b0, 5'd5,  2'b01},
        {2'b00, 1'b1, 1'b0, 1'b1, 5'd8,  2'b01},
        {2'b00, 1'b1, 1'b1, 1'b0, 5'd31, 2'b00},
        {2'b00, 1'b0, 1'b1, 1'b1, 5'd13, 2'b00},
        {2'b00, 1'b0, 1'b0, 1'b0, 5'd3,  2'b11},
        {2'b01, 1'b1, 1'b1, 1'b1, 5'd11, 2'b01}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        csr_raddr = a;
        #0.1;
        d = csr_rdata;
    endtask

    task automatic trap(input logic irq, input logic [4:0] code, input logic [31:0] pc, input logic [31:0] val);
        @(negedge clk);
        trap_req = 1'b1; trap_is_irq = irq; trap_code = code; trap_pc = pc; trap_val = val;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    function automatic logic [31:0] vec_of(input logic [1:0] p);
        case (p)
            2'b00:   return 32'h0000_2000;
            2'b01:   return 32'h0000_3000;
            default: return 32'h0000_4000;
        endcase
    endfunction

    function automatic logic [3:0] base_of(input logic [1:0] p);
        case (p)
            2'b00:   return 4'd4;
            2'b01:   return 4'd8;
            default: return 4'd12;
        endcase
    endfunction

    task automatic reset_checks(input string tag);
        logic [31:0] v;
        chk({tag, " R1 priv"}, 32'(cur_priv), 32'd3);
        chk({tag, " R1 pc"}, next_pc, RST_VEC);
        chk({tag, " R1 taken"}, 32'(trap_taken), 32'd0);
        rd(4'd0, v);  chk({tag, " R1 status"}, v, 32'd0);
        rd(4'd1, v);  chk({tag, " R1 mdeleg"}, v, 32'd0);
        rd(4'd12, v); chk({tag, " R1 mvec"}, v, 32'd0);
        rd(4'd9, v);  chk({tag, " R1 sepc"}, v, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        reset_checks("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("after reset");

        wr(4'd4, 32'h0000_2003);
        wr(4'd8, 32'h0000_3001);
        wr(4'd12, 32'h0000_4002);

        for (int i = 0; i < 8; i++) begin
            logic [1:0] sp, ep;
            logic med, sed, irq;
            logic [4:0] code;
            logic [31:0] onehot, pcv, tv, exp_st;
            string htag, stag;
            sp = VEC[i][11:10]; med = VEC[i][9]; sed = VEC[i][8];
            irq = VEC[i][7]; code = VEC[i][6:2]; ep = VEC[i][1:0];
            onehot = 32'h1 << code;
            wr(4'd1, med ? onehot : ~onehot);
            wr(4'd2, sed ? onehot : ~onehot);
            wr(4'd0, 32'h0000_000B);
            wr(4'd3, 32'(sp));
            pcv = 32'h8000_0000 + 32'(i * 16);
            tv = 32'hA5A5_0000 + 32'(i);
            trap(irq, code, pcv, tv);
            htag = (ep == 2'b00) ? "R3 handler" : "R2 handler";
            chk(htag, 32'(cur_priv), 32'(ep));
            chk("R9 taken", 32'(trap_taken), 32'd1);
            chk("R9 redirect", next_pc, vec_of(ep));
            rd(base_of(ep) + 4'd2, v);
            chk("R7 cause", v, {irq, 26'd0, code});
            rd(base_of(ep) + 4'd1, v);
            chk("R8 epc", v, pcv);
            rd(base_of(ep) + 4'd3, v);
            chk("R8 tval", v, tv);
            case (ep)
                2'b00: begin exp_st = 32'h1A; stag = "R4 status"; end
                2'b01: begin exp_st = 32'h29 | (32'(sp[0]) << 8); stag = "R5 status"; end
                default: begin exp_st = 32'h83 | (32'(sp) << 11); stag = "R6 status"; end
            endcase
            rd(4'd0, v);
            chk(stag, v, exp_st);
            @(negedge clk);
            chk("R9 taken one cycle", 32'(trap_taken), 32'd0);
            chk("R9 pc held", next_pc, vec_of(ep));
        end

        // R10: write in the same cycle as a trap is dropped
        wr(4'd3, 32'd3);
        @(negedge clk);
        trap_req = 1'b1; trap_is_irq = 1'b0; trap_code = 5'd1; trap_pc = 32'h10; trap_val = 32'h20;
        csr_we = 1'b1; csr_addr = 4'd12; csr_wdata = 32'hFFFF_FF00;
        @(negedge clk);
        trap_req = 1'b0; csr_we = 1'b0;
        rd(4'd12, v);
        chk("R10 write dropped", v, 32'h0000_4002);
        chk("R9 redirect with old vector", next_pc, 32'h0000_4000);

        // R8: the other banks stay untouched
        wr(4'd5, 32'h1111);
        wr(4'd9, 32'h2222);
        wr(4'd13, 32'h3333);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd3, 32'd1);
        trap(1'b0, 5'd4, 32'h0000_0444, 32'h55);
        chk("R2 supervisor via mask", 32'(cur_priv), 32'd1);
        rd(4'd5, v);  chk("R8 user epc kept", v, 32'h1111);
        rd(4'd13, v); chk("R8 machine epc kept", v, 32'h3333);
        rd(4'd9, v);  chk("R8 supervisor epc", v, 32'h0000_0444);
        rd(4'd8, v);  chk("R8 vector kept", v, 32'h0000_3001);

        // R10: status mask, privilege write of 2'b10, readback
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);  chk("R10 status mask", v, 32'h0000_19BB);
        wr(4'd3, 32'd2);
        rd(4'd3, v);  chk("R10 priv 2'b10 as machine", v, 32'd3);
        wr(4'd2, 32'h1234_5678);
        rd(4'd2, v);  chk("R10 sdeleg readback", v, 32'h1234_5678);
        rd(4'd11, v); chk("R10 supervisor tval", v, 32'h55);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("mid-run reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule